// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides where each ALU operand of an in-order five-stage integer pipeline comes from. The stages are fetch, decode with register read, execute, memory and write-back. Each cycle it looks at the destination register and write-enable of the two latches downstream of execute: the one between execute and memory, and the one between memory and write-back. It compares them with the source registers of the instruction now in execute, and it drives the select lines of the two ALU input multiplexers. Only read-after-write dependencies need handling, because every read happens in decode and every write happens in write-back, in program order.

A producer's result reaches the next two instructions through the bypass paths. The instruction three slots behind the producer reads the register file, which completes a write before a read in the same cycle. A load has no data until the end of the memory stage. When the instruction directly behind a load needs the loaded register, the block requests a one-cycle stall. Decode and fetch hold, and a bubble goes into execute. After the stall the value arrives through the write-back bypass. The block keeps its own copy of the execute-stage source register numbers, captured from decode each cycle and cleared when a bubble is inserted.

Top module: `bypass_ctrl`

## Requirements
- R1: Each select is 2 bits: 2'b00 takes the register file value, 2'b10 takes the execute/memory latch result, 2'b01 takes the memory/write-back latch result, and 2'b11 is never driven. `sel_a` serves the first source operand and `sel_b` the second.
- R2: An execute-stage source that equals the execute/memory destination selects 2'b10. This holds whenever that latch writes back and the register is not 0.
- R3: A source that matches only the memory/write-back destination, with that latch writing back, selects 2'b01.
- R4: When both latches write the same source register, the execute/memory latch wins and the select is 2'b10.
- R5: Register 0 never causes forwarding and never causes a stall, even when a producer names it as a writing destination.
- R6: A destination whose write-enable is low matches nothing, for forwarding and for the interlock alike.
- R7: `lu_stall` is high while the execute stage holds a writing load whose nonzero destination equals either decode-stage source.
- R8: A stall cycle loads zero source numbers into the execute copy. In the next cycle both selects are 2'b00 and `lu_stall` is low. The waiting consumer then takes the load data with 2'b01.
- R9: A producer three or more slots ahead of its consumer, counting bubbles as slots, gives select 2'b00.
- R10: While `rst_n` is low the execute copy of the source numbers is zero and both selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_AW | First source register of the decode-stage instruction |
| id_rs2 | input | REG_AW | Second source register of the decode-stage instruction |
| idex_rd | input | REG_AW | Destination held in the decode/execute latch |
| idex_wen | input | 1 | Decode/execute instruction writes a register |
| idex_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | REG_AW | Destination held in the execute/memory latch |
| exmem_wen | input | 1 | Execute/memory instruction writes a register |
| memwb_rd | input | REG_AW | Destination held in the memory/write-back latch |
| memwb_wen | input | 1 | Memory/write-back instruction writes a register |
| sel_a | output | 2 | First ALU operand multiplexer select |
| sel_b | output | 2 | Second ALU operand multiplexer select |
| lu_stall | output | 1 | Hold fetch and decode, insert a bubble into execute |

## Verification
The hardest case to reach from the ports is an instruction that stalls behind a load while its other operand depends on the instruction two ahead. The inserted bubble pushes that older producer out of the bypass window, so the operand must come from the register file rather than the write-back latch. The bench runs a short instruction stream through a model of the pipeline latches that obeys the stall output, so bubbles appear exactly where the design asks for them. The stream contains this case, a load feeding a load, and back-to-back loads where only the nearer one is a hazard. The expected selects come from each instruction's distance to its producers in program order.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/ex_src_latch.sv
module ex_src_latch #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic [NSRC-1:0][AW-1:0]  src_d,
  output logic [NSRC-1:0][AW-1:0]  src_q
);
  logic [NSRC-1:0][AW-1:0] src_nxt;

  // a bubble carries register 0 everywhere so it can never match
  always_comb begin
    if (clr) src_nxt = '0;
    else     src_nxt = src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  src_q <= '0;
    else if (en) src_q <= src_nxt;
  end
endmodule

// File: rtl/operand_sel.sv
module operand_sel
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_wen,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_wen,
  output fwd_sel_e      sel_o
);
  logic src_live;
  logic hit_exm;
  logic hit_mwb;

  always_comb begin
    src_live = (src != '0);
    hit_exm  = src_live && exm_wen && (exm_rd == src);
    hit_mwb  = src_live && mwb_wen && (mwb_rd == src);
    // newer result sits in the execute/memory latch
    if (hit_exm)      sel_o = SEL_EXM;
    else if (hit_mwb) sel_o = SEL_WB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wen,
  input  logic                    ex_load,
  output logic                    stall_o
);
  logic any_hit;

  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (id_src[i] == ex_rd) any_hit = 1'b1;
    end
    stall_o = ex_load && ex_wen && (ex_rd != '0) && any_hit;
  end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_wen,
  input  logic              idex_load,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_wen,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_wen,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b,
  output logic              lu_stall
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] id_src;
  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  fwd_sel_e                    op_sel [NSRC];
  logic                        stall_w;

  assign id_src = {id_rs2, id_rs1};

  load_use_detect #(.AW(REG_AW), .NSRC(NSRC)) u_lud (
    .id_src  (id_src),
    .ex_rd   (idex_rd),
    .ex_wen  (idex_wen),
    .ex_load (idex_load),
    .stall_o (stall_w)
  );

  ex_src_latch #(.AW(REG_AW), .NSRC(NSRC)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .clr   (stall_w),
    .src_d (id_src),
    .src_q (ex_src)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    operand_sel #(.AW(REG_AW)) u_sel (
      .src     (ex_src[g]),
      .exm_rd  (exmem_rd),
      .exm_wen (exmem_wen),
      .mwb_rd  (memwb_rd),
      .mwb_wen (memwb_wen),
      .sel_o   (op_sel[g])
    );
  end

  assign sel_a    = op_sel[0];
  assign sel_b    = op_sel[1];
  assign lu_stall = stall_w;
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] idex_rd,
  input logic              idex_wen,
  input logic              idex_load,
  input logic              exmem_wen,
  input logic              memwb_wen,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic              lu_stall,
  input logic [REG_AW-1:0] ex_src_a,
  input logic [REG_AW-1:0] ex_src_b
);
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  p_x0_no_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_src_a == '0) |-> (sel_a == 2'b00)) and ((ex_src_b == '0) |-> (sel_b == 2'b00)));

  p_wen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exmem_wen && !memwb_wen) |-> (sel_a == 2'b00 && sel_b == 2'b00));

  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |-> (idex_load && idex_wen && idex_rd != '0));

  p_bubble_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |=> (sel_a == 2'b00 && sel_b == 2'b00));
endmodule

bind bypass_ctrl bypass_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idex_rd   (idex_rd),
  .idex_wen  (idex_wen),
  .idex_load (idex_load),
  .exmem_wen (exmem_wen),
  .memwb_wen (memwb_wen),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .lu_stall  (lu_stall),
  .ex_src_a  (ex_src[0]),
  .ex_src_b  (ex_src[1])
);

// File: tb/tb_bypass_ctrl.sv
module tb_bypass_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int MAXI = 32;
  localparam logic [1:0] S_RF = 2'b00, S_WB = 2'b01, S_EXM = 2'b10;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, idex_rd, exmem_rd, memwb_rd;
  logic idex_wen, idex_load, exmem_wen, memwb_wen;
  logic [1:0] sel_a, sel_b;
  logic lu_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  bypass_ctrl #(.REG_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .idex_rd(idex_rd), .idex_wen(idex_wen), .idex_load(idex_load),
    .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
    .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
    .sel_a(sel_a), .sel_b(sel_b), .lu_stall(lu_stall)
  );

  logic [AW-1:0] p_rd [MAXI], p_rs1 [MAXI], p_rs2 [MAXI];
  logic p_wen [MAXI], p_ld [MAXI];
  logic e_stall [MAXI];
  int n_ins = 0;
  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_q [$];
  int pc, s_id, s_ex, s_mem, s_wb;
  logic id_seen, stall_s;

  task automatic add_ins(input int rd, input int rs1, input int rs2, input bit wen, input bit ld);
    p_rd[n_ins] = AW'(rd); p_rs1[n_ins] = AW'(rs1); p_rs2[n_ins] = AW'(rs2);
    p_wen[n_ins] = wen; p_ld[n_ins] = ld;
    n_ins++;
  endtask

  function automatic bit writes(input int j, input logic [AW-1:0] s);
    return (s != '0) && p_wen[j] && (p_rd[j] == s);
  endfunction

  function automatic logic [1:0] exp_sel(input int k, input logic [AW-1:0] s);
    int g1, g2, g;
    g1 = 1 + int'(e_stall[k]);
    g2 = (k >= 1) ? g1 + 1 + int'(e_stall[k-1]) : 99;
    g = 99;
    if (k >= 1 && writes(k-1, s)) g = g1;
    else if (k >= 2 && writes(k-2, s)) g = g2;
    if (g == 1) return S_EXM;
    if (g == 2) return S_WB;
    return S_RF;
  endfunction

  // driver: expected items per instruction, in program order
  task automatic build_expect();
    for (int k = 0; k < n_ins; k++) begin
      e_stall[k] = (k > 0) && p_wen[k-1] && p_ld[k-1] && (p_rd[k-1] != '0) &&
                   (p_rd[k-1] == p_rs1[k] || p_rd[k-1] == p_rs2[k]);
    end
    for (int k = 0; k < n_ins; k++) exp_q.push_back({exp_sel(k, p_rs1[k]), exp_sel(k, p_rs2[k])});
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive();
    id_rs1 = (s_id >= 0) ? p_rs1[s_id] : '0;
    id_rs2 = (s_id >= 0) ? p_rs2[s_id] : '0;
    idex_rd = (s_ex >= 0) ? p_rd[s_ex] : '0;
    idex_wen = (s_ex >= 0) ? p_wen[s_ex] : 1'b0;
    idex_load = (s_ex >= 0) ? p_ld[s_ex] : 1'b0;
    exmem_rd = (s_mem >= 0) ? p_rd[s_mem] : '0;
    exmem_wen = (s_mem >= 0) ? p_wen[s_mem] : 1'b0;
    memwb_rd = (s_wb >= 0) ? p_rd[s_wb] : '0;
    memwb_wen = (s_wb >= 0) ? p_wen[s_wb] : 1'b0;
  endtask

  initial begin
    int cyc;
    add_ins(1, 2, 3, 1, 0);    // 0
    add_ins(4, 1, 5, 1, 0);    // 1: R2 a from exe/mem
    add_ins(6, 1, 7, 1, 0);    // 2: R3 a from mem/wb
    add_ins(8, 9, 1, 1, 0);    // 3: R9 b from regfile
    add_ins(10, 11, 12, 1, 0); // 4
    add_ins(10, 13, 14, 1, 0); // 5
    add_ins(15, 10, 10, 1, 0); // 6: R4 newer wins
    add_ins(16, 17, 0, 1, 1);  // 7: load
    add_ins(18, 16, 16, 1, 0); // 8: R7/R8 stall then mem/wb
    add_ins(0, 1, 2, 1, 0);    // 9: writes x0
    add_ins(19, 0, 0, 1, 0);   // 10: R5
    add_ins(0, 3, 0, 1, 1);    // 11: load to x0
    add_ins(20, 0, 4, 1, 0);   // 12: R5 no stall
    add_ins(21, 1, 2, 0, 0);   // 13: no write
    add_ins(22, 21, 21, 1, 0); // 14: R6
    add_ins(23, 1, 0, 1, 1);   // 15: load
    add_ins(24, 1, 23, 1, 0);  // 16: stall on b
    add_ins(25, 2, 0, 1, 1);   // 17: load
    add_ins(26, 3, 0, 1, 1);   // 18: load
    add_ins(27, 25, 26, 1, 0); // 19: stall, a pushed to regfile (R9)
    add_ins(28, 27, 0, 1, 0);  // 20
    add_ins(29, 28, 0, 1, 1);  // 21: load using exe/mem
    add_ins(30, 29, 0, 1, 1);  // 22: load after load stall
    add_ins(0, 0, 0, 0, 0);    // 23
    build_expect();

    s_id = -1; s_ex = -1; s_mem = -1; s_wb = -1; pc = 0; id_seen = 1'b0;
    rst_n = 1'b0;
    drive();
    id_rs1 = 5'd3; id_rs2 = 5'd3; // sources present during reset must not leak
    exmem_rd = 5'd3; exmem_wen = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset selects", {sel_a, sel_b}, {S_RF, S_RF});
    drive();
    rst_n = 1'b1;

    cyc = 0;
    while (pc < n_ins || s_id >= 0 || s_ex >= 0 || s_mem >= 0 || s_wb >= 0) begin
      @(posedge clk);
      #1;
      drive();
      @(negedge clk);
      stall_s = lu_stall;
      // monitor: stall for the instruction in decode
      if (s_id >= 0)
        check($sformatf("R7 stall ins%0d", s_id), {3'b0, lu_stall},
              {3'b0, id_seen ? 1'b0 : e_stall[s_id]});
      else
        check("R7 no stall on empty decode", {3'b0, lu_stall}, 4'b0);
      // monitor: selects for execute stage
      if (s_ex >= 0) begin
        if (exp_q.size() == 0) check("R1 queue underflow", 4'hF, 4'h0);
        else check($sformatf("R2/R3/R4 sel ins%0d", s_ex), {sel_a, sel_b}, exp_q.pop_front());
      end else
        check("R8 bubble selects", {sel_a, sel_b}, {S_RF, S_RF});
      // advance pipeline model at the next edge
      @(posedge clk);
      s_wb = s_mem; s_mem = s_ex;
      if (stall_s) begin
        s_ex = -1; id_seen = 1'b1;
      end else begin
        s_ex = s_id; id_seen = 1'b0;
        s_id = (pc < n_ins) ? pc : -1;
        if (pc < n_ins) pc++;
      end
      #1;
      drive();
      @(negedge clk);
      stall_s = lu_stall;
      if (s_id >= 0)
        check($sformatf("R7 stall ins%0d", s_id), {3'b0, lu_stall},
              {3'b0, id_seen ? 1'b0 : e_stall[s_id]});
      if (s_ex >= 0) begin
        if (exp_q.size() == 0) check("R1 queue underflow", 4'hF, 4'h0);
        else check($sformatf("R5/R6/R9 sel ins%0d", s_ex), {sel_a, sel_b}, exp_q.pop_front());
      end else
        check("R8 bubble selects", {sel_a, sel_b}, {S_RF, S_RF});
      s_wb = s_mem; s_mem = s_ex;
      if (stall_s) begin
        s_ex = -1; id_seen = 1'b1;
      end else begin
        s_ex = s_id; id_seen = 1'b0;
        s_id = (pc < n_ins) ? pc : -1;
        if (pc < n_ins) pc++;
      end
      cyc++;
      if (cyc > 500) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: pipeline did not drain, actual=%0d expected<=500", cyc);
        break;
      end
    end
    check("R1 all instructions compared", 4'(exp_q.size()), 4'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule